// File: doc/BRIEF.md
# SIMT Lane Mask Sequencer

This block keeps the lane-enable mask of an eight-lane SIMT core while that core runs data-dependent branches. The core runs one instruction stream. A branch does not redirect a program counter. The block narrows the mask to the lanes whose per-lane condition is true. On the else command it switches to the lanes that were active at the branch and whose condition was false. On the join command it restores the mask that was in force before the branch. The taken side always runs first, and the two sides never overlap.

A mask stack of four entries holds the mask and condition saved by each open branch, so branches can nest four deep. A path whose mask is empty is flagged, so the sequencer can jump over it. The block also accepts a barrier command. After a barrier, issue is held until every enabled lane reports that no instructions are outstanding. Commands presented while issue is held are not accepted.

Top module: `lane_mask_seq`

## Requirements
- R1: After reset, lane_en is all ones, nest_depth is 0, stk_err is 0 and issue_hold is 0.
- R2: An accepted branch (cmd_op = 2'b01) while nest_depth < 4 pushes the current mask and the condition. The next cycle, lane_en equals the old lane_en AND cmd_cond, and nest_depth has risen by one.
- R3: An accepted else (cmd_op = 2'b10) with a non-empty stack sets lane_en to the mask saved by the innermost branch AND NOT the condition saved with it. nest_depth is unchanged.
- R4: An accepted join (cmd_op = 2'b11) with a non-empty stack restores lane_en to the mask saved by the innermost branch and lowers nest_depth by one.
- R5: skip_path is 1 exactly when lane_en is all zeros.
- R6: The following commands set stk_err and leave lane_en and nest_depth unchanged: a branch at nest_depth 4, and an else or a join at nest_depth 0.
- R7: Once stk_err is set, it stays at 1 until reset.
- R8: An accepted barrier (cmd_op = 2'b00) raises issue_hold in the next cycle. issue_hold stays at 1 while any enabled lane has a non-zero outstanding count. lane_pend lane i occupies bits [3i+2:3i]. issue_hold falls one cycle after all enabled lanes read zero. Counts of disabled lanes have no effect.
- R9: A command with cmd_valid high while issue_hold is 1 is ignored: lane_en, nest_depth and stk_err do not change.
- R10: Four nested branches followed by four joins restore the masks in last-in, first-out order, ending with the mask from before the outermost branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 barrier, 01 branch, 10 else, 11 join |
| cmd_cond | input | 8 | Per-lane branch condition, sampled on a branch |
| lane_pend | input | 24 | Per-lane outstanding instruction count, 3 bits per lane |
| lane_en | output | 8 | Lane-enable mask to the ALU array |
| skip_path | output | 1 | Current path has no active lane |
| nest_depth | output | 3 | Number of open branches on the stack |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |
| issue_hold | output | 1 | Barrier holding issue |

## Verification
The assertions assume that cmd_op is meaningful only while cmd_valid is high. They also assume that lane_pend changes only through the source's own retire behaviour, and that no particular timing relation is needed between lane_pend and commands. The stimulus changes every input one half-period away from the sampling edge. It leaves cmd_valid high for exactly one edge per command. During barrier tests it moves lane_pend to zero only after the hold has been observed, so the clearing edge is known.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {
    OP_BARRIER = 2'b00,
    OP_BRANCH  = 2'b01,
    OP_ELSE    = 2'b10,
    OP_JOIN    = 2'b11
  } mask_op_e;
endpackage

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LANES-1:0] push_mask,
  input  logic [LANES-1:0] push_cond,
  output logic [LANES-1:0] top_mask,
  output logic [LANES-1:0] top_cond,
  output logic [DW-1:0]    depth,
  output logic             full,
  output logic             empty
);
  localparam logic [DW-1:0] DMAX = DW'(DEPTH);

  logic [LANES-1:0] mask_mem [DEPTH];
  logic [LANES-1:0] cond_mem [DEPTH];
  logic [DW-1:0]    depth_q, depth_d;
  logic             depth_ld;
  logic [DW-1:0]    rd_idx;

  // One write enable per entry; only the slot at the current depth loads.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = push && (depth_q == DW'(i));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        mask_mem[i] <= push_mask;
        cond_mem[i] <= push_cond;
      end
    end
  end

  always_comb begin
    depth_ld = push ^ pop;
    depth_d  = depth_q;
    if (push && !pop) depth_d = depth_q + DW'(1);
    else if (pop && !push) depth_d = depth_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= '0;
    else if (depth_ld) depth_q <= depth_d;
  end

  assign empty  = (depth_q == '0);
  assign full   = (depth_q == DMAX);
  assign rd_idx = empty ? '0 : depth_q - DW'(1);
  assign top_mask = mask_mem[rd_idx];
  assign top_cond = cond_mem[rd_idx];
  assign depth    = depth_q;
endmodule

// File: rtl/mask_ctrl.sv
module mask_ctrl
  import simt_mask_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  mask_op_e         op,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] top_mask,
  input  logic [LANES-1:0] top_cond,
  input  logic             full,
  input  logic             empty,
  output logic             push,
  output logic             pop,
  output logic [LANES-1:0] mask,
  output logic             err
);
  logic [LANES-1:0] mask_q, mask_d;
  logic             err_q, err_d;

  always_comb begin
    mask_d = mask_q;
    err_d  = err_q;
    push   = 1'b0;
    pop    = 1'b0;
    if (fire) begin
      unique case (op)
        OP_BRANCH: begin
          if (full) err_d = 1'b1;
          else begin
            push   = 1'b1;
            mask_d = mask_q & cond;
          end
        end
        OP_ELSE: begin
          if (empty) err_d = 1'b1;
          else mask_d = top_mask & ~top_cond;
        end
        OP_JOIN: begin
          if (empty) err_d = 1'b1;
          else begin
            pop    = 1'b1;
            mask_d = top_mask;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      err_q  <= 1'b0;
    end else if (fire) begin
      mask_q <= mask_d;
      err_q  <= err_d;
    end
  end

  assign mask = mask_q;
  assign err  = err_q;
endmodule

// File: rtl/barrier_hold.sv
module barrier_hold #(
  parameter int LANES = 8,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set,
  input  logic [LANES-1:0]       lane_en,
  input  logic [LANES*CNT_W-1:0] lane_pend,
  output logic                   hold
);
  logic [LANES-1:0] busy;
  logic             idle;
  logic             hold_q, hold_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign busy[i] = lane_en[i] && (lane_pend[i*CNT_W +: CNT_W] != '0);
  end
  assign idle = ~|busy;

  always_comb begin
    hold_d = hold_q;
    if (set) hold_d = 1'b1;
    else if (hold_q && idle) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else hold_q <= hold_d;
  end

  assign hold = hold_q;
endmodule

// File: rtl/lane_mask_seq.sv
module lane_mask_seq
  import simt_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int DW    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [1:0]             cmd_op,
  input  logic [LANES-1:0]       cmd_cond,
  input  logic [LANES*CNT_W-1:0] lane_pend,
  output logic [LANES-1:0]       lane_en,
  output logic                   skip_path,
  output logic [DW-1:0]          nest_depth,
  output logic                   stk_err,
  output logic                   issue_hold
);
  mask_op_e         op;
  logic             fire;
  logic             push, pop, full, empty;
  logic [LANES-1:0] top_mask, top_cond, mask;

  assign op   = mask_op_e'(cmd_op);
  assign fire = cmd_valid && !issue_hold;

  mask_stack #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) stack_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_mask(mask), .push_cond(cmd_cond),
    .top_mask(top_mask), .top_cond(top_cond),
    .depth(nest_depth), .full(full), .empty(empty)
  );

  mask_ctrl #(.LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .cond(cmd_cond),
    .top_mask(top_mask), .top_cond(top_cond), .full(full), .empty(empty),
    .push(push), .pop(pop), .mask(mask), .err(stk_err)
  );

  barrier_hold #(.LANES(LANES), .CNT_W(CNT_W)) bar_i (
    .clk(clk), .rst_n(rst_n), .set(fire && op == OP_BARRIER),
    .lane_en(mask), .lane_pend(lane_pend), .hold(issue_hold)
  );

  assign lane_en   = mask;
  assign skip_path = ~|mask;
endmodule

// File: rtl/lane_mask_seq_chk.sv
module lane_mask_seq_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [LANES-1:0] cmd_cond,
  input logic [LANES-1:0] lane_en,
  input logic             skip_path,
  input logic [DW-1:0]    nest_depth,
  input logic             stk_err,
  input logic             issue_hold
);
  logic acc;
  assign acc = cmd_valid && !issue_hold;

  a_r2_branch_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 2'b01 && nest_depth != DW'(DEPTH) |=>
      lane_en == ($past(lane_en) & $past(cmd_cond)) && nest_depth == $past(nest_depth) + DW'(1));

  a_r3_else_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 2'b10 |=> $stable(nest_depth));

  a_r4_join_pops: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 2'b11 && nest_depth != '0 |=> nest_depth == $past(nest_depth) - DW'(1));

  a_r5_skip_flag: assert property (@(posedge clk) disable iff (!rst_n)
    skip_path == (lane_en == '0));

  a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 2'b01 && nest_depth == DW'(DEPTH) |=> stk_err && $stable(lane_en) && $stable(nest_depth));

  a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op[1] && nest_depth == '0 |=> stk_err && $stable(lane_en) && $stable(nest_depth));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

  a_r8_barrier_holds: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 2'b00 |=> issue_hold);

  a_r9_held_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hold && cmd_valid |=> $stable(lane_en) && $stable(nest_depth) && $stable(stk_err));

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= DW'(DEPTH));
endmodule

bind lane_mask_seq lane_mask_seq_chk #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_cond(cmd_cond), .lane_en(lane_en), .skip_path(skip_path),
  .nest_depth(nest_depth), .stk_err(stk_err), .issue_hold(issue_hold)
);

// File: tb/lane_mask_seq_tb_top.sv
`timescale 1ns/1ps
module lane_mask_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_cond;
  logic [23:0] lane_pend;
  logic [7:0]  lane_en;
  logic        skip_path;
  logic [2:0]  nest_depth;
  logic        stk_err;
  logic        issue_hold;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lane_mask_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cond(cmd_cond), .lane_pend(lane_pend), .lane_en(lane_en),
    .skip_path(skip_path), .nest_depth(nest_depth), .stk_err(stk_err),
    .issue_hold(issue_hold)
  );

  // {op, cond, expected mask, expected depth}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {2'b01, 8'h0F, 8'h0F, 3'd1},
    {2'b01, 8'h33, 8'h03, 3'd2},
    {2'b10, 8'h00, 8'h0C, 3'd2},
    {2'b11, 8'h00, 8'h0F, 3'd1},
    {2'b10, 8'h00, 8'hF0, 3'd1},
    {2'b01, 8'h00, 8'h00, 3'd2},
    {2'b10, 8'h00, 8'hF0, 3'd2},
    {2'b11, 8'h00, 8'hF0, 3'd1},
    {2'b11, 8'h00, 8'hFF, 3'd0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [7:0] cond);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_cond = cond;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_cond = '0; lane_pend = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 lane_en", 32'(lane_en), 32'hFF);
    check("R1 depth", 32'(nest_depth), 0);
    check("R1 err", 32'(stk_err), 0);
    check("R1 hold", 32'(issue_hold), 0);

    // Table walk: R2 branch, R3 else, R4 join, R5 skip flag
    for (int i = 0; i < NV; i++) begin
      string req;
      logic [1:0] op;
      op = VEC[i][20:19];
      req = (op == 2'b01) ? "R2" : (op == 2'b10) ? "R3" : "R4";
      send(op, VEC[i][18:11]);
      check({req, " mask"}, 32'(lane_en), 32'(VEC[i][10:3]));
      check({req, " depth"}, 32'(nest_depth), 32'(VEC[i][2:0]));
      check("R5 skip", 32'(skip_path), 32'(VEC[i][10:3] == 8'h00));
    end

    // R10 four-deep nesting, R6 overflow, R7 sticky
    send(2'b01, 8'hFE); send(2'b01, 8'hFC); send(2'b01, 8'hF8); send(2'b01, 8'hF0);
    check("R10 mask at depth 4", 32'(lane_en), 32'hF0);
    check("R10 depth 4", 32'(nest_depth), 4);
    send(2'b01, 8'h0F);
    check("R6 overflow err", 32'(stk_err), 1);
    check("R6 overflow mask", 32'(lane_en), 32'hF0);
    check("R6 overflow depth", 32'(nest_depth), 4);
    send(2'b11, 8'h00); check("R10 pop1", 32'(lane_en), 32'hF8);
    send(2'b11, 8'h00); check("R10 pop2", 32'(lane_en), 32'hFC);
    send(2'b11, 8'h00); check("R10 pop3", 32'(lane_en), 32'hFE);
    send(2'b11, 8'h00); check("R10 pop4", 32'(lane_en), 32'hFF);
    check("R10 depth 0", 32'(nest_depth), 0);
    check("R7 err sticky", 32'(stk_err), 1);

    // R6 underflow on join and on else
    do_reset();
    check("R1 err after reset", 32'(stk_err), 0);
    send(2'b11, 8'h00);
    check("R6 join underflow err", 32'(stk_err), 1);
    check("R6 join underflow mask", 32'(lane_en), 32'hFF);
    check("R6 join underflow depth", 32'(nest_depth), 0);
    do_reset();
    send(2'b10, 8'h00);
    check("R6 else underflow err", 32'(stk_err), 1);
    check("R6 else underflow mask", 32'(lane_en), 32'hFF);

    // R8 barrier with a busy enabled lane, R9 ignored commands
    do_reset();
    lane_pend = 24'(3) << 6;      // lane 2 count 3
    send(2'b00, 8'h00);
    check("R8 hold raised", 32'(issue_hold), 1);
    repeat (3) @(negedge clk);
    check("R8 hold while busy", 32'(issue_hold), 1);
    send(2'b01, 8'h0F);
    check("R9 mask unchanged", 32'(lane_en), 32'hFF);
    check("R9 depth unchanged", 32'(nest_depth), 0);
    send(2'b11, 8'h00);
    check("R9 err unchanged", 32'(stk_err), 0);
    lane_pend = '0;
    @(negedge clk);
    check("R8 hold released", 32'(issue_hold), 0);

    // R8 disabled lane count ignored
    send(2'b01, 8'h0F);
    lane_pend = 24'(5) << 18;     // lane 6, disabled
    send(2'b00, 8'h00);
    check("R8 hold one cycle", 32'(issue_hold), 1);
    @(negedge clk);
    check("R8 disabled lane ignored", 32'(issue_hold), 0);
    lane_pend = '0;

    finish_run();
  end
endmodule